// File: doc/BRIEF.md
# Barrier Synchronization Unit for Interleaved Hardware Threads

This block keeps the barrier state for a small set of interleaved hardware threads. When a thread reaches a WAIT operation in the last execute stage, the stage presents the issuing thread id, a participation mask and a sync-point index. The unit holds one pending register per sync point and a per-thread wait-state vector. From these it drives, for every thread, a hold-PC line, an annul-exceptions line and a one-cycle illegal-wait exception pulse.

The barrier uses parity, not a counter. The first arrival at a sync point finds the pending register clear and flips the bits of every other participant. Each later arrival flips only its own bit. The barrier is complete when the register returns to zero. Release is ordered: the thread that arrived first resumes one cycle before the others.

A WAIT that names a participant that is not active is rejected with an exception. If a participant is killed while a thread is waiting on it, the waiting thread is released with an exception and the barrier is cancelled.

Top module: `barrier_sync`

## Requirements
- R1: Reset clears every pending register, every wait-state bit and all exception pulses, so `hold_pc`, `annul_exc`, `illegal_wait` and `pend_flat` all read zero.
- R2: A WAIT is accepted when `wait_valid` is high, the issuing thread is not waiting, its own bit is set in `wait_mask`, and all mask members are active. On a first arrival (selected register zero), the register takes the mask bits of the other participants. `pend_flat` bit 4*s+n is thread n's bit of sync point s.
- R3: An accepted WAIT that finds the selected register non-zero toggles only the issuing thread's bit.
- R4: An accepted WAIT sets `hold_pc` for the issuing thread from the cycle after the issue edge. `annul_exc` always equals `hold_pc`.
- R5: A WAIT from a thread that is already waiting, or whose own bit is clear in its mask, changes no state and raises no exception.
- R6: If the register returns to zero at edge E, the first-arriving thread's hold clears at edge E+1 and the other members' holds clear at edge E+2.
- R7: A WAIT whose mask names an inactive thread raises `illegal_wait` for the issuing thread for one cycle and changes no other state.
- R8: If a participant other than the waiting thread itself goes inactive while a thread waits, the next edge does three things: it pulses `illegal_wait` for the waiting thread, clears that thread's hold, and clears the pending register of its sync point.
- R9: A WAIT whose mask holds only the issuing thread completes at once: the hold is set for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wait_valid | input | 1 | A WAIT operation is presented this cycle |
| wait_tid | input | 2 | Issuing thread id |
| wait_mask | input | 4 | Participating threads, bit n is thread n |
| wait_sel | input | 1 | Sync-point index |
| thread_active | input | 4 | Thread-active vector |
| hold_pc | output | 4 | Per thread: keep the PC |
| annul_exc | output | 4 | Per thread: drop exceptions of the held instruction |
| illegal_wait | output | 4 | Per thread: illegal-wait exception pulse |
| pend_flat | output | 8 | Pending registers of both sync points, thread n of sync point s at bit 4*s+n |

## Verification
The bench builds the unit with the default four threads and two sync points. This makes the mapping of the pending byte, three-way barriers and a leader with a higher id than the last arrival all observable at the ports. Switching between both sync points lets the bench confirm that a barrier on one point leaves the other register alone. Releasing the leader and the remaining members one cycle apart shows the resume order directly on `hold_pc`.

// File: rtl/barrier_pkg.sv
package barrier_pkg;
    localparam int DEF_THREADS = 4;
    localparam int DEF_SYNCS   = 2;

    function automatic int sel_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/barrier_slot.sv
module barrier_slot #(
    parameter int NUM_THREADS = 4
) (
    input  logic [NUM_THREADS-1:0] pend_q,
    input  logic                   hit,
    input  logic [NUM_THREADS-1:0] own_bit,
    input  logic [NUM_THREADS-1:0] mask,
    output logic [NUM_THREADS-1:0] pend_nx,
    output logic                   first,
    output logic                   done
);
    logic [NUM_THREADS-1:0] flip;

    always_comb begin
        first   = hit && (pend_q == '0);
        flip    = first ? (mask & ~own_bit) : own_bit;
        pend_nx = hit ? (pend_q ^ flip) : pend_q;
        done    = hit && (pend_nx == '0);
    end
endmodule

// File: rtl/barrier_watch.sv
module barrier_watch #(
    parameter int NUM_THREADS = 4,
    parameter int SELF        = 0
) (
    input  logic                   waiting,
    input  logic [NUM_THREADS-1:0] grp,
    input  logic [NUM_THREADS-1:0] active,
    output logic                   broken,
    output logic                   dropped
);
    logic [NUM_THREADS-1:0] others;

    always_comb begin
        others  = grp & ~(NUM_THREADS'(1) << SELF);
        dropped = waiting && !active[SELF];
        broken  = waiting && active[SELF] && ((others & ~active) != '0);
    end
endmodule

// File: rtl/barrier_sync.sv
module barrier_sync #(
    parameter int NUM_THREADS = barrier_pkg::DEF_THREADS,
    parameter int NUM_SYNCS   = barrier_pkg::DEF_SYNCS
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      wait_valid,
    input  logic [$clog2(NUM_THREADS)-1:0]            wait_tid,
    input  logic [NUM_THREADS-1:0]                    wait_mask,
    input  logic [barrier_pkg::sel_width(NUM_SYNCS)-1:0] wait_sel,
    input  logic [NUM_THREADS-1:0]                    thread_active,
    output logic [NUM_THREADS-1:0]                    hold_pc,
    output logic [NUM_THREADS-1:0]                    annul_exc,
    output logic [NUM_THREADS-1:0]                    illegal_wait,
    output logic [NUM_SYNCS*NUM_THREADS-1:0]          pend_flat
);
    localparam int TID_W = $clog2(NUM_THREADS);
    localparam int SEL_W = barrier_pkg::sel_width(NUM_SYNCS);

    typedef struct packed {
        logic [NUM_SYNCS-1:0][NUM_THREADS-1:0]   pend;
        logic [NUM_SYNCS-1:0][TID_W-1:0]         lead;
        logic [NUM_THREADS-1:0]                  ws;
        logic [NUM_THREADS-1:0]                  rel_lead;
        logic [NUM_THREADS-1:0]                  rel_rest;
        logic [NUM_THREADS-1:0]                  rel_late;
        logic [NUM_THREADS-1:0]                  illegal;
        logic [NUM_THREADS-1:0][NUM_THREADS-1:0] grp;
        logic [NUM_THREADS-1:0][SEL_W-1:0]       gsel;
    } state_t;

    state_t st_q, st_d;

    logic [NUM_THREADS-1:0] own_bit;
    logic                   issue;
    logic                   absent;
    logic                   accept;
    logic                   reject;
    logic [NUM_THREADS-1:0] broken;
    logic [NUM_THREADS-1:0] dropped;
    logic [NUM_SYNCS-1:0]   hit;
    logic [NUM_SYNCS-1:0]   first;
    logic [NUM_SYNCS-1:0]   done;
    logic [NUM_SYNCS-1:0][NUM_THREADS-1:0] pend_nx;

    assign own_bit = NUM_THREADS'(1) << wait_tid;
    assign issue   = wait_valid && !st_q.ws[wait_tid] && wait_mask[wait_tid];
    assign absent  = (wait_mask & ~thread_active) != '0;
    assign accept  = issue && !absent;
    assign reject  = issue && absent;

    for (genvar s = 0; s < NUM_SYNCS; s++) begin : g_slot
        assign hit[s] = accept && (wait_sel == SEL_W'(s));
        barrier_slot #(.NUM_THREADS(NUM_THREADS)) slot_i (
            .pend_q  (st_q.pend[s]),
            .hit     (hit[s]),
            .own_bit (own_bit),
            .mask    (wait_mask),
            .pend_nx (pend_nx[s]),
            .first   (first[s]),
            .done    (done[s])
        );
    end

    for (genvar i = 0; i < NUM_THREADS; i++) begin : g_watch
        barrier_watch #(.NUM_THREADS(NUM_THREADS), .SELF(i)) watch_i (
            .waiting (st_q.ws[i]),
            .grp     (st_q.grp[i]),
            .active  (thread_active),
            .broken  (broken[i]),
            .dropped (dropped[i])
        );
    end

    always_comb begin
        logic                   clr;
        logic [NUM_THREADS-1:0] lead_vec;

        st_d          = st_q;
        st_d.illegal  = broken;
        st_d.rel_lead = '0;
        st_d.rel_rest = '0;
        st_d.rel_late = st_q.rel_rest;
        st_d.ws       = st_q.ws & ~st_q.rel_lead & ~st_q.rel_late
                        & ~broken & ~dropped;

        for (int s = 0; s < NUM_SYNCS; s++) begin
            clr = 1'b0;
            for (int i = 0; i < NUM_THREADS; i++) begin
                if (broken[i] && (st_q.gsel[i] == SEL_W'(s))) begin
                    clr = 1'b1;
                end
            end
            st_d.pend[s] = clr ? '0 : pend_nx[s];
            if (first[s]) begin
                st_d.lead[s] = wait_tid;
            end
            lead_vec = first[s] ? own_bit : (NUM_THREADS'(1) << st_q.lead[s]);
            if (done[s]) begin
                st_d.rel_lead = lead_vec;
                st_d.rel_rest = wait_mask & ~lead_vec;
            end
        end

        if (accept) begin
            st_d.ws            = st_d.ws | own_bit;
            st_d.grp[wait_tid]  = wait_mask;
            st_d.gsel[wait_tid] = wait_sel;
        end

        if (reject) begin
            st_d.illegal = st_d.illegal | own_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_pc      = st_q.ws;
    assign annul_exc    = st_q.ws;
    assign illegal_wait = st_q.illegal;
    assign pend_flat    = st_q.pend;
endmodule

// File: rtl/barrier_sync_chk.sv
module barrier_sync_chk #(
    parameter int NUM_THREADS = 4,
    parameter int NUM_SYNCS   = 2
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               wait_valid,
    input logic [$clog2(NUM_THREADS)-1:0]     wait_tid,
    input logic [NUM_THREADS-1:0]             wait_mask,
    input logic [NUM_THREADS-1:0]             thread_active,
    input logic [NUM_THREADS-1:0]             hold_pc,
    input logic [NUM_THREADS-1:0]             annul_exc,
    input logic [NUM_THREADS-1:0]             illegal_wait,
    input logic [NUM_SYNCS*NUM_THREADS-1:0]   pend_flat
);
    localparam int TID_W = $clog2(NUM_THREADS);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (hold_pc == '0 && pend_flat == '0 && illegal_wait == '0));

    p_annul_follows_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        annul_exc == hold_pc);

    for (genvar i = 0; i < NUM_THREADS; i++) begin : g_thr
        p_wait_sets_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (wait_valid && wait_tid == TID_W'(i) && !hold_pc[i] && wait_mask[i]
             && ((wait_mask & ~thread_active) == '0)) |=> hold_pc[i]);

        p_bad_member_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (wait_valid && wait_tid == TID_W'(i) && !hold_pc[i] && wait_mask[i]
             && ((wait_mask & ~thread_active) != '0)) |=> (illegal_wait[i] && !hold_pc[i]));

        p_break_releases_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (illegal_wait[i] && $past(hold_pc[i])) |-> !hold_pc[i]);
    end
endmodule

bind barrier_sync barrier_sync_chk #(
    .NUM_THREADS(NUM_THREADS),
    .NUM_SYNCS  (NUM_SYNCS)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .wait_valid    (wait_valid),
    .wait_tid      (wait_tid),
    .wait_mask     (wait_mask),
    .thread_active (thread_active),
    .hold_pc       (hold_pc),
    .annul_exc     (annul_exc),
    .illegal_wait  (illegal_wait),
    .pend_flat     (pend_flat)
);

// File: tb/barrier_sync_tb_top.sv
`timescale 1ns/1ps
module barrier_sync_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wait_valid = 1'b0;
    logic [1:0] wait_tid = '0;
    logic [3:0] wait_mask = '0;
    logic [0:0] wait_sel = '0;
    logic [3:0] thread_active = 4'hF;
    logic [3:0] hold_pc, annul_exc, illegal_wait;
    logic [7:0] pend_flat;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    barrier_sync dut_i (
        .clk(clk), .rst_n(rst_n), .wait_valid(wait_valid), .wait_tid(wait_tid),
        .wait_mask(wait_mask), .wait_sel(wait_sel), .thread_active(thread_active),
        .hold_pc(hold_pc), .annul_exc(annul_exc), .illegal_wait(illegal_wait),
        .pend_flat(pend_flat)
    );

    // {valid, tid, mask, sel, active, exp_hold, exp_pend, exp_ill, req}
    localparam int NV = 23;
    localparam logic [31:0] VEC [0:NV-1] = '{
        {1'b1, 2'd0, 4'b0011, 1'b0, 4'hF, 4'b0001, 8'h02, 4'h0, 4'd2}, // R2 first arrival
        {1'b0, 2'd0, 4'b0000, 1'b0, 4'hF, 4'b0001, 8'h02, 4'h0, 4'd4}, // R4 still held
        {1'b1, 2'd1, 4'b0011, 1'b0, 4'hF, 4'b0011, 8'h00, 4'h0, 4'd3}, // R3 last arrival
        {1'b0, 2'd0, 4'b0000, 1'b0, 4'hF, 4'b0010, 8'h00, 4'h0, 4'd6}, // R6 leader out
        {1'b0, 2'd0, 4'b0000, 1'b0, 4'hF, 4'b0000, 8'h00, 4'h0, 4'd6}, // R6 rest out
        {1'b1, 2'd2, 4'b1110, 1'b1, 4'hF, 4'b0100, 8'hA0, 4'h0, 4'd2}, // R2 sync point 1
        {1'b1, 2'd0, 4'b1110, 1'b1, 4'hF, 4'b0100, 8'hA0, 4'h0, 4'd5}, // R5 own bit clear
        {1'b1, 2'd3, 4'b1110, 1'b1, 4'hF, 4'b1100, 8'h20, 4'h0, 4'd3}, // R3 middle arrival
        {1'b1, 2'd2, 4'b1110, 1'b1, 4'hF, 4'b1100, 8'h20, 4'h0, 4'd5}, // R5 already waiting
        {1'b1, 2'd1, 4'b1110, 1'b1, 4'hF, 4'b1110, 8'h00, 4'h0, 4'd3}, // R3 completes
        {1'b0, 2'd0, 4'b0000, 1'b0, 4'hF, 4'b1010, 8'h00, 4'h0, 4'd6}, // R6 leader T2 out
        {1'b0, 2'd0, 4'b0000, 1'b0, 4'hF, 4'b0000, 8'h00, 4'h0, 4'd6}, // R6
        {1'b1, 2'd1, 4'b0110, 1'b0, 4'hB, 4'b0000, 8'h00, 4'h2, 4'd7}, // R7 T2 inactive
        {1'b0, 2'd0, 4'b0000, 1'b0, 4'hF, 4'b0000, 8'h00, 4'h0, 4'd7}, // R7 pulse ends
        {1'b1, 2'd3, 4'b1000, 1'b0, 4'hF, 4'b1000, 8'h00, 4'h0, 4'd9}, // R9 solo
        {1'b0, 2'd0, 4'b0000, 1'b0, 4'hF, 4'b0000, 8'h00, 4'h0, 4'd9}, // R9
        {1'b1, 2'd0, 4'b0101, 1'b1, 4'hF, 4'b0001, 8'h40, 4'h0, 4'd2}, // R2
        {1'b0, 2'd0, 4'b0000, 1'b0, 4'hB, 4'b0000, 8'h00, 4'h1, 4'd8}, // R8 partner killed
        {1'b0, 2'd0, 4'b0000, 1'b0, 4'hF, 4'b0000, 8'h00, 4'h0, 4'd8}, // R8
        {1'b1, 2'd3, 4'b1001, 1'b0, 4'hF, 4'b1000, 8'h01, 4'h0, 4'd2}, // R2 leader T3
        {1'b1, 2'd0, 4'b1001, 1'b0, 4'hF, 4'b1001, 8'h00, 4'h0, 4'd3}, // R3
        {1'b0, 2'd0, 4'b0000, 1'b0, 4'hF, 4'b0001, 8'h00, 4'h0, 4'd6}, // R6 T3 first
        {1'b0, 2'd0, 4'b0000, 1'b0, 4'hF, 4'b0000, 8'h00, 4'h0, 4'd6}  // R6
    };

    task automatic check(input int req, input string what, input logic [7:0] act,
                         input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [1:0] t, input logic [3:0] m,
                        input logic s, input logic [3:0] a);
        @(negedge clk);
        wait_valid = v; wait_tid = t; wait_mask = m; wait_sel = s; thread_active = a;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 5);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check(1, "hold", {4'h0, hold_pc}, 8'h00);
        check(1, "pend", pend_flat, 8'h00);
        check(1, "ill", {4'h0, illegal_wait}, 8'h00);
        @(negedge clk) rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            step(VEC[k][31], VEC[k][30:29], VEC[k][28:25], VEC[k][24], VEC[k][23:20]);
            check(int'(VEC[k][3:0]), "hold", {4'h0, hold_pc}, {4'h0, VEC[k][19:16]});
            check(4, "annul", {4'h0, annul_exc}, {4'h0, VEC[k][19:16]});
            check(int'(VEC[k][3:0]), "pend", pend_flat, VEC[k][15:8]);
            check(int'(VEC[k][3:0]), "ill", {4'h0, illegal_wait}, {4'h0, VEC[k][7:4]});
        end

        // R1: reset in the middle of a barrier
        step(1'b1, 2'd0, 4'b0011, 1'b0, 4'hF);
        check(2, "pre-reset pend", pend_flat, 8'h02);
        @(negedge clk);
        wait_valid = 1'b0; rst_n = 1'b0;
        @(posedge clk); #1;
        check(1, "mid reset hold", {4'h0, hold_pc}, 8'h00);
        check(1, "mid reset pend", pend_flat, 8'h00);
        @(negedge clk) rst_n = 1'b1;
        // R1: after reset the same WAIT is again a first arrival
        step(1'b1, 2'd1, 4'b0011, 1'b0, 4'hF);
        check(1, "post reset pend", pend_flat, 8'h01);
        check(1, "post reset hold", {4'h0, hold_pc}, 8'h02);
        step(1'b0, 2'd0, 4'b0000, 1'b0, 4'hF);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule